// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Masked-Write Aliases

This block is the register file and pad control for one port of eight general-purpose pins. Software reaches it through a plain memory-mapped bus: an address, a write strobe, write data and read data that is returned combinationally. Three writable registers decide each pin's state:
- a mode register hands the pin to GPIO control;
- a direction register selects driving or sensing;
- a drive-level register holds the value put on the pad.

A fourth, read-only register shows the pad levels after a two-flop synchronizer. The synchronized levels are also exported so that neighbouring interrupt or debounce logic can use them.

Each writable register can also be reached at a second address. At that address the upper byte of the write data is a per-pin write mask and the lower byte carries the new values. Software can then change one pin, or a few pins, in a single bus write, with no read-modify-write. The drive-level register is fully separate from the direction register. Software can therefore load the level first and turn the driver on afterwards, so a pin never drives a stale value.

Top module: `gpio_port_mw`

## Requirements
- R1: A write to a plain register address loads all eight bits from wdata[7:0], and the new value is visible from the next clock edge. The plain addresses are mode 0x00, direction 0x10 and drive level 0x20.
- R2: A write to a masked alias address updates each pin whose bit in wdata[15:8] is 1 with the matching bit of wdata[7:0]. Each alias address is its plain address plus ALIAS_OFS (default 0x80): mode 0x80, direction 0x90, drive level 0xA0.
- R3: During a masked alias write, every pin whose mask bit is 0 keeps its previous register value.
- R4: pad_oe_o[i] is 1 exactly when both the mode bit and the direction bit of pin i are 1. pad_out_o always equals the drive-level register, whatever the direction bits are.
- R5: The input register (address 0x30) and sync_in_o show each pin_i level after exactly two rising clock edges.
- R6: While rst_ni is low, the mode, direction and drive-level registers are cleared to 0 and the synchronizer is cleared to 0, so no pin is driven.
- R7: A read from a masked alias address returns the matching plain register in rdata[7:0], with every higher bit 0.
- R8: A write to the input register address or to an unmapped address changes no register. A read from an unmapped address returns 0.
- R9: rdata_o reflects addr_i in the same cycle, with no read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte address of the register |
| we_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | DATA_W (32) | Write data; in an alias write, [15:8] is the mask and [7:0] the values |
| rdata_o | output | DATA_W (32) | Combinational read data |
| pin_i | input | PINS (8) | Pad input levels, asynchronous |
| pad_out_o | output | PINS (8) | Level to drive on each pad |
| pad_oe_o | output | PINS (8) | Pad driver enable |
| gpio_mode_o | output | PINS (8) | Pins under GPIO control |
| sync_in_o | output | PINS (8) | Synchronized pad levels for neighbouring logic |

## Verification
Embedded assertions check on every cycle that:
- a plain write loads the register;
- a masked write sets the selected pins and leaves the others alone;
- the synchronizer output trails the pins by two edges;
- a write to the input address leaves all state untouched.

Only the bench's scenarios can show the end-to-end effects. These include the ordering of level before enable, the gating of the pad enable by the mode bits, alias readback with zeroed upper bits, unmapped accesses, and reset values. The bench compares every cycle against a behavioural model under directed sequences and a long stream of random accesses.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned NUM_WR   = 3;
  localparam int unsigned STRIDE   = 16;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_LEVEL = 2'd2,
    SEL_INPUT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned ALIAS_OFS = 'h80
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              we_i,
  output logic [gpio_mw_pkg::NUM_WR-1:0]    plain_wr_o,
  output logic [gpio_mw_pkg::NUM_WR-1:0]    mask_wr_o,
  output logic [gpio_mw_pkg::NUM_REGS-1:0]  rd_hit_o
);
  import gpio_mw_pkg::*;

  logic [NUM_REGS-1:0] plain_hit;
  logic [NUM_REGS-1:0] alias_hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] PLAIN_A = ADDR_W'(i * STRIDE);
    localparam logic [ADDR_W-1:0] ALIAS_A = ADDR_W'(i * STRIDE + ALIAS_OFS);
    assign plain_hit[i] = (addr_i == PLAIN_A);
    if (i < NUM_WR) begin : g_alias
      assign alias_hit[i] = (addr_i == ALIAS_A);
      assign plain_wr_o[i] = we_i & plain_hit[i];
      assign mask_wr_o[i]  = we_i & alias_hit[i];
    end else begin : g_ro
      assign alias_hit[i] = 1'b0;
    end
    assign rd_hit_o[i] = plain_hit[i] | alias_hit[i];
  end
endmodule

// File: rtl/gpio_mw_reg.sv
module gpio_mw_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         mwr_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] msk_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wr_i)       q_d = val_i;
    else if (mwr_i) q_d = (q_o & ~msk_i) | (val_i & msk_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  AST_PLAIN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(val_i)); // R1
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mwr_i && !wr_i) |=> ((q_o & $past(msk_i)) == ($past(val_i) & $past(msk_i)))); // R2
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mwr_i && !wr_i) |=> ((q_o & ~$past(msk_i)) == ($past(q_o) & ~$past(msk_i)))); // R3
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= 1'b0;
        sync_o[i] <= 1'b0;
      end else begin
        meta_q[i] <= pin_i[i];
        sync_o[i] <= meta_q[i];
      end
    end
  end

  // edges seen since reset, saturating; arms the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd2)   age_q <= age_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> sync_o == $past(pin_i, 2)); // R5
endmodule

// File: rtl/gpio_port_mw.sv
module gpio_port_mw #(
  parameter int unsigned PINS      = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ALIAS_OFS = 'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pad_out_o,
  output logic [PINS-1:0]   pad_oe_o,
  output logic [PINS-1:0]   gpio_mode_o,
  output logic [PINS-1:0]   sync_in_o
);
  import gpio_mw_pkg::*;

  localparam int unsigned PAD_W = DATA_W - PINS;

  logic [NUM_WR-1:0]   plain_wr, mask_wr;
  logic [NUM_REGS-1:0] rd_hit;
  logic [PINS-1:0]     wval, wmsk;
  logic [PINS-1:0]     regs [NUM_REGS];
  logic [PINS-1:0]     rval;

  assign wval = wdata_i[PINS-1:0];
  assign wmsk = wdata_i[2*PINS-1:PINS];

  gpio_mw_decode #(.ADDR_W(ADDR_W), .ALIAS_OFS(ALIAS_OFS)) u_dec (
    .addr_i     (addr_i),
    .we_i       (we_i),
    .plain_wr_o (plain_wr),
    .mask_wr_o  (mask_wr),
    .rd_hit_o   (rd_hit)
  );

  for (genvar i = 0; i < NUM_WR; i++) begin : g_reg
    gpio_mw_reg #(.W(PINS)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (plain_wr[i]),
      .mwr_i  (mask_wr[i]),
      .val_i  (wval),
      .msk_i  (wmsk),
      .q_o    (regs[i])
    );
  end

  gpio_mw_sync #(.W(PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (regs[SEL_INPUT])
  );

  always_comb begin
    rval = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_hit[i]) rval |= regs[i];
  end

  assign rdata_o     = {{PAD_W{1'b0}}, rval};
  assign gpio_mode_o = regs[SEL_MODE];
  assign pad_oe_o    = regs[SEL_MODE] & regs[SEL_DIR];
  assign pad_out_o   = regs[SEL_LEVEL];
  assign sync_in_o   = regs[SEL_INPUT];

  AST_INPUT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(SEL_INPUT * STRIDE)) |=>
      ($stable(gpio_mode_o) && $stable(pad_out_o) && $stable(regs[SEL_DIR]))); // R8
  AST_RD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_hit)); // R9
endmodule

// File: tb/sim_gpio_port_mw.sv
module sim_gpio_port_mw;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 8;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0;
  logic        we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  pin = 0;
  logic [7:0]  pad_out, pad_oe, mode, sync_in;

  int tests = 0, fails = 0;

  gpio_port_mw u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .gpio_mode_o(mode), .sync_in_o(sync_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model
  byte unsigned m_mode, m_dir, m_lvl;
  byte unsigned pq[$];

  function automatic byte unsigned m_in();
    return pq[0];
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00, 8'h80: return {24'b0, m_mode};
      8'h10, 8'h90: return {24'b0, m_dir};
      8'h20, 8'hA0: return {24'b0, m_lvl};
      8'h30:        return {24'b0, m_in()};
      default:      return 32'b0;
    endcase
  endfunction

  function automatic byte unsigned mwrite(byte unsigned old, logic [31:0] d);
    byte unsigned mk = d[15:8];
    return (old & ~mk) | (d[7:0] & mk);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_dir = 0; m_lvl = 0;
      pq = {8'h00, 8'h00};
    end else begin
      pq.push_back(pin);
      void'(pq.pop_front());
      if (we) begin
        case (addr)
          8'h00: m_mode = wdata[7:0];
          8'h10: m_dir  = wdata[7:0];
          8'h20: m_lvl  = wdata[7:0];
          8'h80: m_mode = mwrite(m_mode, wdata);
          8'h90: m_dir  = mwrite(m_dir, wdata);
          8'hA0: m_lvl  = mwrite(m_lvl, wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, addr);
    end
  endtask

  function automatic string rd_tag(logic [7:0] a);
    if (a == 8'h80 || a == 8'h90 || a == 8'hA0) return "R7";
    if (a == 8'h30) return "R5";
    if (a == 8'h00 || a == 8'h10 || a == 8'h20) return "R1";
    return "R8";
  endfunction

  // per-cycle comparison at the falling edge
  always @(negedge clk) if (rst_n) begin
    chk(rd_tag(addr), rdata, m_read(addr));
    chk("R4 oe", {24'b0, pad_oe}, {24'b0, m_mode & m_dir});
    chk("R4 out", {24'b0, pad_out}, {24'b0, m_lvl});
    chk("R5", {24'b0, sync_in}, {24'b0, m_in()});
    chk("R1 mode", {24'b0, mode}, {24'b0, m_mode});
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    addr = a; we = 1; wdata = d;
    @(negedge clk); #1;
    we = 0; wdata = 0;
  endtask

  task automatic rd_expect(string req, logic [7:0] a, logic [31:0] exp);
    #1 addr = a; #1;
    chk(req, rdata, exp); // R9: same-cycle read
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3); #1;
    // R6: reset state
    chk("R6 oe", {24'b0, pad_oe}, 0);
    chk("R6 out", {24'b0, pad_out}, 0);
    chk("R6 mode", {24'b0, mode}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    rd_expect("R6", 8'h00, 0);

    // R1 / R4: level first, direction set, mode still 0 -> no drive
    wr(8'h20, 32'h0000_00A5);
    wr(8'h10, 32'h0000_00FF);
    rd_expect("R1", 8'h20, 32'hA5);
    chk("R4", {24'b0, pad_oe}, 0);
    chk("R4", {24'b0, pad_out}, 32'hA5);

    // R2: masked mode write, low nibble only
    wr(8'h80, 32'hFFFF_0FFF);
    rd_expect("R2", 8'h00, 32'h0F);
    chk("R4", {24'b0, pad_oe}, 32'h0F);

    // R3: clear upper nibble of level, lower kept
    wr(8'hA0, 32'h0000_F000);
    rd_expect("R3", 8'h20, 32'h05);
    wr(8'h90, 32'h0000_0100);
    rd_expect("R3", 8'h10, 32'hFE);

    // R7: alias reads
    rd_expect("R7", 8'h80, 32'h0F);
    rd_expect("R7", 8'hA0, 32'h05);

    // R8: input and unmapped writes ignored, unmapped read zero
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'hB0, 32'hFFFF_FFFF);
    rd_expect("R8", 8'h00, 32'h0F);
    rd_expect("R8", 8'h10, 32'hFE);
    rd_expect("R8", 8'h20, 32'h05);
    rd_expect("R8", 8'h44, 32'h0);

    // R5: pin change visible after two edges
    @(negedge clk); #1; pin = 8'h3C; addr = 8'h30;
    @(negedge clk); #1; chk("R5", {24'b0, sync_in}, 0);
    @(negedge clk); #1; chk("R5", {24'b0, sync_in}, 32'h3C);

    // random traffic, checked by the model every cycle
    for (int i = 0; i < 2000; i++) begin
      int unsigned r = $urandom;
      @(negedge clk); #1;
      pin = $urandom;
      case (r % 11)
        0: addr = 8'h00; 1: addr = 8'h10; 2: addr = 8'h20; 3: addr = 8'h30;
        4: addr = 8'h80; 5: addr = 8'h90; 6: addr = 8'hA0; 7: addr = 8'hB0;
        8: addr = 8'h08; 9: addr = 8'hC0; default: addr = $urandom;
      endcase
      we = r[8];
      wdata = $urandom;
    end
    @(negedge clk); #1; we = 0;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule